// File: doc/BRIEF.md
# I/O Link Throughput Counter Unit

This block sits beside one valid/ready data interface and keeps running statistics on it, all in the monitor clock domain. Every enabled clock cycle lands in exactly one of three classes. A cycle where the beat is accepted counts as active. A cycle where the source offers data but the sink withholds ready counts as busy. A cycle with no valid data counts as idle. Two further counters accumulate payload bytes and end-of-packet beats. Software divides the byte delta by the cycle delta to get bandwidth, and the busy share shows how much the sink is throttling the link.

Software reaches the counters through a small word-addressed register port, and the counters keep running while they are read. Three ways of sampling are offered. In the plain way, software reads the live values twice and subtracts. In the second way, software sets a freeze bit that copies all five counters into shadow registers at once. In the third way, each low-half read also restarts the counter it read, so consecutive reads give consecutive windows. Counters are `CNT_W` bits wide, 48 by default, and each one is read as a low word of `LO_W` bits followed by a high word. A hold register keeps the two halves of one read consistent.

Top module: `xfer_stat_unit`

## Requirements
- R1: With enable set (CTRL at address 0, bit 0), a cycle with `mon_valid` and `mon_ready` both high adds one to the active counter (counter 0, low half at address 2, high half at address 3).
- R2: With enable set, a cycle with `mon_valid` high and `mon_ready` low adds one to the busy counter (counter 1, addresses 4 and 5).
- R3: With enable set, a cycle with `mon_valid` low adds one to the idle counter (counter 2, addresses 6 and 7), whatever `mon_ready` is.
- R4: The three cycle classes never overlap. Between a clear and a freeze, the active, busy and idle counts sum to the number of enabled cycles in between.
- R5: On an accepted beat, the byte counter (counter 3, addresses 8 and 9) adds the number of set bits in `mon_keep`. A beat that is not accepted adds nothing, whatever its keep bits are.
- R6: The packet counter (counter 4, addresses 10 and 11) adds one for each accepted beat with `mon_last` high. `mon_last` on a busy or idle cycle is not counted.
- R7: A CTRL write that sets freeze (bit 1) while freeze is clear copies all five counters into shadow registers. The copy holds the values from before that write cycle. While freeze is set, counter reads return the shadow values and live counting continues. After freeze is cleared, reads return the live values again.
- R8: With read-to-clear mode on (CTRL bit 2) and freeze clear, a low-half read returns the counter value, and the live counter restarts from the increment of that same cycle. With freeze set, reads clear nothing.
- R9: A low-half read returns bits `[LO_W-1:0]` of the counter and captures its upper bits into one shared hold register. A high-half read returns that hold register, zero-extended, not the current upper bits.
- R10: While enable is clear, no counter changes, whatever the interface does.
- R11: A CTRL write with bit 3 set zeroes all counters, the shadows, the hold register and the overflow flag in that cycle, and counts nothing in that cycle. Bits 0 to 2 of the same write are loaded as usual.
- R12: Counters wrap modulo 2^CNT_W. A wrap of any counter sets a sticky overflow flag (STATUS at address 1, bit 0), which only a soft clear or reset removes.
- R13: Read data appears on `reg_rdata` in the cycle after `reg_rd_en` and holds until the next read. CTRL reads back enable in bit 0, freeze in bit 1 and read-to-clear in bit 2. Unmapped addresses read 0. After reset all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_valid | input | 1 | Valid of the observed interface |
| mon_ready | input | 1 | Ready of the observed interface |
| mon_last | input | 1 | End-of-packet marker of the observed beat |
| mon_keep | input | DATA_BYTES | Byte enables of the observed beat |
| reg_rd_en | input | 1 | Register read strobe, one cycle per read |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after the strobe |

## Verification
The traffic patterns are chosen so that each one changes only one counter. Steady accepted beats move only the active counter, stalled beats move only busy, and an empty link moves only idle. Keep masks of full, partial, single and zero bytes, together with stalled beats that carry keep and last, separate a correct byte and packet count from one that ignores ready. Long random mixes of traffic and register operations check the sum rule, the freeze copy and the read-to-clear restart against a cycle model. A second instance, with narrow counters and an 8-bit low half, makes the upper-half hold and the counter wrap reachable within the run.

// File: rtl/xstat_pkg.sv
package xstat_pkg;

    localparam int NUM_CNT    = 5;
    localparam int IDX_ACTIVE = 0;
    localparam int IDX_BUSY   = 1;
    localparam int IDX_IDLE   = 2;
    localparam int IDX_BYTES  = 3;
    localparam int IDX_PKTS   = 4;

    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_STAT  = 1;
    localparam int CNT_BASE   = 2;

    localparam int CTRL_EN    = 0;
    localparam int CTRL_FRZ   = 1;
    localparam int CTRL_RTC   = 2;
    localparam int CTRL_CLR   = 3;

    typedef struct packed {
        logic rtc;
        logic freeze;
        logic enable;
    } ctrl_t;

endpackage

// File: rtl/xstat_classify.sv
module xstat_classify
    import xstat_pkg::*;
#(
    parameter int DATA_BYTES = 8,
    parameter int INC_W      = $clog2(DATA_BYTES + 1)
) (
    input  logic                               enable,
    input  logic                               valid,
    input  logic                               ready,
    input  logic                               last,
    input  logic [DATA_BYTES-1:0]              keep,
    output logic [NUM_CNT-1:0][INC_W-1:0]      inc
);

    logic [INC_W-1:0] byte_sum;

    always_comb begin
        byte_sum = '0;
        for (int b = 0; b < DATA_BYTES; b++) begin
            byte_sum = byte_sum + INC_W'(keep[b]);
        end
    end

    always_comb begin
        inc = '0;
        if (enable) begin
            if (valid && ready) begin
                inc[IDX_ACTIVE] = INC_W'(1);
                inc[IDX_BYTES]  = byte_sum;
                inc[IDX_PKTS]   = INC_W'(last);
            end else if (valid) begin
                inc[IDX_BUSY]   = INC_W'(1);
            end else begin
                inc[IDX_IDLE]   = INC_W'(1);
            end
        end
    end

endmodule

// File: rtl/xstat_counter.sv
module xstat_counter #(
    parameter int CNT_W = 48,
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc,
    input  logic             clr_all,
    input  logic             restart,
    input  logic             snap,
    output logic [CNT_W-1:0] live,
    output logic [CNT_W-1:0] shadow,
    output logic             wrap
);

    typedef struct packed {
        logic [CNT_W-1:0] live;
        logic [CNT_W-1:0] shadow;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [CNT_W-1:0] base;
    logic [CNT_W:0]   sum;

    always_comb begin
        st_d = st_q;
        base = restart ? '0 : st_q.live;
        sum  = {1'b0, base} + (CNT_W + 1)'(inc);
        wrap = sum[CNT_W] & ~clr_all;
        if (snap) begin
            st_d.shadow = st_q.live;
        end
        if (clr_all) begin
            st_d.live   = '0;
            st_d.shadow = '0;
        end else begin
            st_d.live   = sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign live   = st_q.live;
    assign shadow = st_q.shadow;

endmodule

// File: rtl/xstat_regs.sv
module xstat_regs
    import xstat_pkg::*;
#(
    parameter int CNT_W = 48,
    parameter int LO_W  = 32,
    parameter int AW    = 5,
    parameter int HI_W  = CNT_W - LO_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 addr,
    input  logic [31:0]                   wdata,
    input  logic [NUM_CNT-1:0][CNT_W-1:0] live,
    input  logic [NUM_CNT-1:0][CNT_W-1:0] shadow,
    input  logic                          wrap_any,
    output logic                          enable,
    output logic                          clr_all,
    output logic                          snap,
    output logic [NUM_CNT-1:0]            restart,
    output logic [31:0]                   rdata
);

    typedef struct packed {
        ctrl_t             ctrl;
        logic              ovf;
        logic [HI_W-1:0]   hold;
        logic [31:0]       rdata;
    } reg_state_t;

    reg_state_t                    st_d, st_q;
    logic                          ctrl_wr;
    logic [NUM_CNT-1:0]            lo_hit;
    logic [NUM_CNT-1:0]            hi_hit;
    logic [NUM_CNT-1:0][CNT_W-1:0] src;
    logic                          wdata_unused;

    assign wdata_unused = ^wdata[31:CTRL_CLR+1];

    always_comb begin
        st_d    = st_q;
        ctrl_wr = wr_en && (addr == AW'(ADDR_CTRL));
        clr_all = ctrl_wr && wdata[CTRL_CLR];
        snap    = ctrl_wr && wdata[CTRL_FRZ] && !st_q.ctrl.freeze && !clr_all;

        for (int k = 0; k < NUM_CNT; k++) begin
            src[k]     = st_q.ctrl.freeze ? shadow[k] : live[k];
            lo_hit[k]  = rd_en && (addr == AW'(CNT_BASE + 2 * k));
            hi_hit[k]  = rd_en && (addr == AW'(CNT_BASE + 2 * k + 1));
            restart[k] = lo_hit[k] && st_q.ctrl.rtc && !st_q.ctrl.freeze;
        end

        if (rd_en) begin
            st_d.rdata = '0;
            if (addr == AW'(ADDR_CTRL)) begin
                st_d.rdata[CTRL_EN]  = st_q.ctrl.enable;
                st_d.rdata[CTRL_FRZ] = st_q.ctrl.freeze;
                st_d.rdata[CTRL_RTC] = st_q.ctrl.rtc;
            end
            if (addr == AW'(ADDR_STAT)) begin
                st_d.rdata[0] = st_q.ovf;
            end
            for (int k = 0; k < NUM_CNT; k++) begin
                if (lo_hit[k]) begin
                    st_d.rdata = 32'(src[k][LO_W-1:0]);
                    st_d.hold  = src[k][CNT_W-1:LO_W];
                end
                if (hi_hit[k]) begin
                    st_d.rdata = 32'(st_q.hold);
                end
            end
        end

        st_d.ovf = st_q.ovf | wrap_any;

        if (ctrl_wr) begin
            st_d.ctrl.enable = wdata[CTRL_EN];
            st_d.ctrl.freeze = wdata[CTRL_FRZ];
            st_d.ctrl.rtc    = wdata[CTRL_RTC];
        end
        if (clr_all) begin
            st_d.ovf  = 1'b0;
            st_d.hold = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enable = st_q.ctrl.enable;
    assign rdata  = st_q.rdata;

endmodule

// File: rtl/xfer_stat_unit.sv
module xfer_stat_unit
    import xstat_pkg::*;
#(
    parameter int CNT_W      = 48,
    parameter int LO_W       = 32,
    parameter int DATA_BYTES = 8,
    parameter int AW         = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mon_valid,
    input  logic                  mon_ready,
    input  logic                  mon_last,
    input  logic [DATA_BYTES-1:0] mon_keep,
    input  logic                  reg_rd_en,
    input  logic                  reg_wr_en,
    input  logic [AW-1:0]         reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata
);

    localparam int INC_W = $clog2(DATA_BYTES + 1);

    logic [NUM_CNT-1:0][INC_W-1:0] inc_w;
    logic [NUM_CNT-1:0][CNT_W-1:0] live_w;
    logic [NUM_CNT-1:0][CNT_W-1:0] shadow_w;
    logic [NUM_CNT-1:0]            wrap_w;
    logic [NUM_CNT-1:0]            restart_w;
    logic                          enable_w;
    logic                          clr_w;
    logic                          snap_w;

    xstat_classify #(
        .DATA_BYTES (DATA_BYTES),
        .INC_W      (INC_W)
    ) u_classify (
        .enable (enable_w),
        .valid  (mon_valid),
        .ready  (mon_ready),
        .last   (mon_last),
        .keep   (mon_keep),
        .inc    (inc_w)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        xstat_counter #(
            .CNT_W (CNT_W),
            .INC_W (INC_W)
        ) u_counter (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (inc_w[g]),
            .clr_all (clr_w),
            .restart (restart_w[g]),
            .snap    (snap_w),
            .live    (live_w[g]),
            .shadow  (shadow_w[g]),
            .wrap    (wrap_w[g])
        );
    end

    xstat_regs #(
        .CNT_W (CNT_W),
        .LO_W  (LO_W),
        .AW    (AW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (reg_rd_en),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .live     (live_w),
        .shadow   (shadow_w),
        .wrap_any (|wrap_w),
        .enable   (enable_w),
        .clr_all  (clr_w),
        .snap     (snap_w),
        .restart  (restart_w),
        .rdata    (reg_rdata)
    );

endmodule

// File: rtl/xstat_checks.sv
module xstat_checks
    import xstat_pkg::*;
#(
    parameter int CNT_W      = 48,
    parameter int DATA_BYTES = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          enable,
    input logic                          clr_all,
    input logic                          snap,
    input logic [NUM_CNT-1:0]            restart,
    input logic [NUM_CNT-1:0][CNT_W-1:0] live,
    input logic [NUM_CNT-1:0][CNT_W-1:0] shadow
);

    logic                          past_ok;
    logic                          prev_plain;
    logic                          prev_on;
    logic                          prev_clr;
    logic                          prev_snap;
    logic [NUM_CNT-1:0][CNT_W-1:0] prev_live;
    logic [NUM_CNT-1:0][CNT_W-1:0] prev_shadow;
    logic [NUM_CNT-1:0][CNT_W-1:0] dlt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok     <= 1'b0;
            prev_plain  <= 1'b0;
            prev_on     <= 1'b0;
            prev_clr    <= 1'b0;
            prev_snap   <= 1'b0;
            prev_live   <= '0;
            prev_shadow <= '0;
        end else begin
            past_ok     <= 1'b1;
            prev_plain  <= !clr_all && (restart == '0);
            prev_on     <= enable;
            prev_clr    <= clr_all;
            prev_snap   <= snap;
            prev_live   <= live;
            prev_shadow <= shadow;
        end
    end

    always_comb begin
        for (int k = 0; k < NUM_CNT; k++) begin
            dlt[k] = live[k] - prev_live[k];
        end
    end

    // R4: exactly one cycle class advances per enabled cycle
    a_r4_one_class: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && prev_plain && prev_on) |->
        (dlt[IDX_ACTIVE] + dlt[IDX_BUSY] + dlt[IDX_IDLE] == CNT_W'(1)));

    // R10: nothing moves while counting is disabled
    a_r10_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && prev_plain && !prev_on) |-> (live == prev_live));

    // R5: one beat never adds more bytes than lanes
    a_r5_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && prev_plain) |-> (dlt[IDX_BYTES] <= CNT_W'(DATA_BYTES)));

    // R6: a packet end is only counted together with an accepted beat
    a_r6_pkt_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && prev_plain) |-> (dlt[IDX_PKTS] <= dlt[IDX_ACTIVE]));

    // R7: shadows stay put unless a snapshot or clear happened
    a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !prev_snap && !prev_clr) |-> (shadow == prev_shadow));

    // R11: soft clear leaves every counter and shadow at zero
    a_r11_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && prev_clr) |-> ((live == '0) && (shadow == '0)));

endmodule

bind xfer_stat_unit xstat_checks #(
    .CNT_W      (CNT_W),
    .DATA_BYTES (DATA_BYTES)
) u_checks (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable_w),
    .clr_all (clr_w),
    .snap    (snap_w),
    .restart (restart_w),
    .live    (live_w),
    .shadow  (shadow_w)
);

// File: tb/test_xfer_stat_unit.sv
`timescale 1ns/1ps
module test_xfer_stat_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0, ready = 1'b0, last = 1'b0;
    logic [7:0]  keep = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_m, rdata_s;

    always #2 clk = ~clk;

    xfer_stat_unit #(.CNT_W(48), .LO_W(32), .DATA_BYTES(8), .AW(5)) i_xfer_stat_unit (
        .clk(clk), .rst_n(rst_n), .mon_valid(valid), .mon_ready(ready), .mon_last(last),
        .mon_keep(keep), .reg_rd_en(rd), .reg_wr_en(wr), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata_m));

    xfer_stat_unit #(.CNT_W(12), .LO_W(8), .DATA_BYTES(8), .AW(5)) i_xfer_stat_unit_small (
        .clk(clk), .rst_n(rst_n), .mon_valid(valid), .mon_ready(ready), .mon_last(last),
        .mon_keep(keep), .reg_rd_en(rd), .reg_wr_en(wr), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata_s));

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    int unsigned wid[2] = '{48, 12};
    int unsigned low[2] = '{32, 8};
    longint unsigned m_live[2][5];
    longint unsigned m_shadow[2][5];
    longint unsigned m_hold[2];
    longint unsigned exp_rd[2];
    bit m_ovf[2], m_en[2], m_frz[2], m_rtc[2];
    logic [31:0] got_m;

    function automatic longint unsigned msk(int unsigned w);
        if (w >= 64) return '1;
        return (64'd1 << w) - 64'd1;
    endfunction

    function automatic void model(int i, bit v, bit r, bit lst, logic [7:0] kp,
                                  bit rdx, bit wrx, logic [4:0] a, logic [31:0] wd);
        longint unsigned inc[5];
        longint unsigned src, nv;
        int restart_k;
        int k;
        inc = '{default: 0};
        restart_k = -1;
        if (m_en[i]) begin
            if (v && r) begin
                inc[0] = 1; inc[3] = $countones(kp); inc[4] = lst;
            end else if (v) inc[1] = 1;
            else inc[2] = 1;
        end
        if (wrx && a == 5'd0 && wd[3]) begin
            for (int c = 0; c < 5; c++) begin m_live[i][c] = 0; m_shadow[i][c] = 0; end
            m_hold[i] = 0; m_ovf[i] = 0;
            m_en[i] = wd[0]; m_frz[i] = wd[1]; m_rtc[i] = wd[2];
            return;
        end
        if (rdx) begin
            exp_rd[i] = 0;
            if (a == 5'd0) exp_rd[i] = {61'd0, m_rtc[i], m_frz[i], m_en[i]};
            else if (a == 5'd1) exp_rd[i] = {63'd0, m_ovf[i]};
            else if (a >= 5'd2 && a < 5'd12) begin
                k = (int'(a) - 2) / 2;
                src = m_frz[i] ? m_shadow[i][k] : m_live[i][k];
                if (a[0] == 1'b0) begin
                    exp_rd[i] = src & msk(low[i]);
                    m_hold[i] = src >> low[i];
                    if (m_rtc[i] && !m_frz[i]) restart_k = k;
                end else begin
                    exp_rd[i] = m_hold[i];
                end
            end
        end
        if (wrx && a == 5'd0) begin
            if (wd[1] && !m_frz[i])
                for (int c = 0; c < 5; c++) m_shadow[i][c] = m_live[i][c];
            m_en[i] = wd[0]; m_frz[i] = wd[1]; m_rtc[i] = wd[2];
        end
        for (int c = 0; c < 5; c++) begin
            nv = ((c == restart_k) ? 64'd0 : m_live[i][c]) + inc[c];
            if (nv > msk(wid[i])) begin m_ovf[i] = 1'b1; nv = nv & msk(wid[i]); end
            m_live[i][c] = nv;
        end
    endfunction

    task automatic check(string tag, string what, longint unsigned act, longint unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(bit v, bit r, bit lst, logic [7:0] kp,
                        bit rdx, bit wrx, logic [4:0] a, logic [31:0] wd, string tag);
        @(negedge clk);
        valid = v; ready = r; last = lst; keep = kp;
        rd = rdx; wr = wrx; addr = a; wdata = wd;
        @(posedge clk);
        model(0, v, r, lst, kp, rdx, wrx, a, wd);
        model(1, v, r, lst, kp, rdx, wrx, a, wd);
        #1;
        if (rdx) begin
            got_m = rdata_m;
            check(tag, $sformatf("wide addr %0d", a), longint'(rdata_m), exp_rd[0] & 64'hFFFF_FFFF);
            check(tag, $sformatf("narrow addr %0d", a), longint'(rdata_s), exp_rd[1] & 64'hFFFF_FFFF);
        end
    endtask

    task automatic idle(int n);
        for (int c = 0; c < n; c++) step(0, 0, 0, 8'h00, 0, 0, 5'd0, 32'd0, "");
    endtask

    task automatic rreg(logic [4:0] a, string tag);
        step(0, 0, 0, 8'h00, 1, 0, a, 32'd0, tag);
    endtask

    task automatic wreg(logic [31:0] d);
        step(0, 0, 0, 8'h00, 0, 1, 5'd0, d, "");
    endtask

    task automatic beat(bit v, bit r, bit lst, logic [7:0] kp);
        step(v, r, lst, kp, 0, 0, 5'd0, 32'd0, "");
    endtask

    task automatic rnd_beat();
        beat(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
    endtask

    initial begin
        #800000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        longint unsigned sum3;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2; i++) begin
            for (int c = 0; c < 5; c++) begin m_live[i][c] = 0; m_shadow[i][c] = 0; end
            m_hold[i] = 0; m_ovf[i] = 0; m_en[i] = 0; m_frz[i] = 0; m_rtc[i] = 0; exp_rd[i] = 0;
        end
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R13", "rdata after reset", longint'(rdata_m), 0);

        // R13: reset values over the whole map, plus an unmapped address
        for (int a = 0; a < 13; a++) rreg(5'(a), "R13");

        // R10: traffic while disabled leaves every counter untouched
        for (int c = 0; c < 12; c++) rnd_beat();
        for (int a = 2; a < 12; a += 2) rreg(5'(a), "R10");

        wreg(32'h1);
        // R1: accepted beats
        for (int c = 0; c < 5; c++) beat(1, 1, 0, 8'hFF);
        rreg(5'd2, "R1");
        // R2: stalled beats
        for (int c = 0; c < 3; c++) beat(1, 0, 0, 8'hFF);
        rreg(5'd4, "R2");
        // R3: empty link, ready high or low
        beat(0, 1, 0, 8'hFF); beat(0, 0, 1, 8'h0F);
        rreg(5'd6, "R3");
        // R5: keep masks full, partial, single, none, and a stalled beat
        beat(1, 1, 0, 8'hFF); beat(1, 1, 0, 8'h0F); beat(1, 1, 0, 8'h01);
        beat(1, 1, 0, 8'h00); beat(1, 0, 0, 8'hFF);
        rreg(5'd8, "R5");
        // R6: last on accepted, stalled and idle cycles
        beat(1, 1, 1, 8'hFF); beat(1, 0, 1, 8'hFF); beat(0, 0, 1, 8'h00); beat(1, 1, 1, 8'h03);
        rreg(5'd10, "R6");
        rreg(5'd0, "R13");

        // R11: soft clear with traffic in the same cycle
        step(1, 1, 1, 8'hFF, 0, 1, 5'd0, 32'h9, "");
        for (int a = 0; a < 12; a++) rreg(5'(a), "R11");

        // R7: freeze, keep counting, read shadows, then release
        for (int c = 0; c < 20; c++) rnd_beat();
        wreg(32'h3);
        for (int c = 0; c < 10; c++) rnd_beat();
        for (int a = 2; a < 12; a++) rreg(5'(a), "R7");
        wreg(32'h1);
        for (int a = 2; a < 12; a += 2) rreg(5'(a), "R7");

        // R8: read-to-clear, reads during accepted beats
        wreg(32'h5);
        for (int c = 0; c < 15; c++) rnd_beat();
        step(1, 1, 1, 8'h7F, 1, 0, 5'd2, 32'd0, "R8");
        step(1, 1, 0, 8'h3F, 1, 0, 5'd2, 32'd0, "R8");
        step(1, 1, 1, 8'hFF, 1, 0, 5'd8, 32'd0, "R8");
        step(1, 0, 0, 8'hFF, 1, 0, 5'd8, 32'd0, "R8");
        step(0, 0, 0, 8'h00, 1, 0, 5'd10, 32'd0, "R8");
        // R8: with freeze set nothing restarts
        wreg(32'h7);
        for (int c = 0; c < 6; c++) rnd_beat();
        rreg(5'd6, "R8"); rreg(5'd6, "R8");
        wreg(32'h5);
        rreg(5'd6, "R8"); rreg(5'd6, "R8");

        // R9: upper half is captured on the low read (narrow instance crosses 256)
        wreg(32'h9);
        idle(250);
        rreg(5'd6, "R9");
        idle(20);
        rreg(5'd7, "R9");
        rreg(5'd6, "R9");
        rreg(5'd7, "R9");

        // R4: explicit sum of the three classes over a counted window
        wreg(32'h9);
        for (int c = 0; c < 137; c++) rnd_beat();
        wreg(32'h3);
        rreg(5'd2, "R4"); sum3 = longint'(got_m);
        rreg(5'd4, "R4"); sum3 += longint'(got_m);
        rreg(5'd6, "R4"); sum3 += longint'(got_m);
        check("R4", "class sum over window", sum3, 137);
        wreg(32'h1);

        // R12: wrap of the narrow counters, sticky flag, cleared by soft clear
        wreg(32'h9);
        idle(4200);
        rreg(5'd1, "R12");
        rreg(5'd6, "R12"); rreg(5'd7, "R12");
        idle(10);
        rreg(5'd1, "R12");
        wreg(32'h9);
        rreg(5'd1, "R12");

        // R4: random traffic mixed with register operations
        for (int c = 0; c < 3000; c++) begin
            int unsigned pick;
            pick = $urandom % 64;
            if (pick < 8)
                step(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
                     1, 0, 5'($urandom % 12), 32'd0, "R4");
            else if (pick == 8)
                step(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
                     0, 1, 5'd0, {28'd0, ($urandom % 8 == 0), 1'($urandom), 1'($urandom), ($urandom % 6 != 0)}, "");
            else
                rnd_beat();
        end
        for (int a = 0; a < 12; a++) rreg(5'(a), "R4");

        idle(2);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule